// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block holds the program-counter values that a small microcontroller core must come back to. A subroutine call or an acknowledged interrupt stores the current program-counter value. A plain return or an interrupt return removes the newest value and presents it as the address to resume at. The stack has its own storage, apart from program and data memory. No software read or write path reaches the entries or the pointer.

The block also decides when an interrupt may be taken. A request is acknowledged only when it is pending, interrupts are enabled and a free level exists. With all levels in use the request waits, and it is taken once a return has lowered the occupancy. A call into a full stack is never refused. It writes over the oldest entry, so the newest return addresses are always the ones kept.

Top module: `ret_addr_stack`

## Requirements
- R1: After an asynchronous reset (rst_ni low), empty_o is 1, full_o is 0, the occupancy is 0 and ret_addr_o is 0.
- R2: A cycle with call_i high stores pc_i. From the next cycle on, ret_addr_o shows that value.
- R3: ret_i or reti_i removes the newest entry. During the cycle of the pop, ret_addr_o shows the entry being removed. Afterwards it shows the entry below it, in last-in first-out order.
- R4: full_o is 1 exactly when DEPTH (6) entries are held, and empty_o is 1 exactly when none are held.
- R5: A push into a full stack overwrites the oldest entry and the occupancy stays at 6. Six pops then return the six most recent values, newest first, and leave the stack empty.
- R6: irq_ack_o is high in the same cycle as irq_req_i, provided irq_en_i is high and the stack is not full. An acknowledgment pushes pc_i.
- R7: While the stack is full, irq_ack_o stays low, even in a cycle that also pops. The request is acknowledged in the first cycle after a pop has lowered the occupancy.
- R8: When a push and a pop occur in the same cycle, the pop is applied first. The newest entry is replaced by pc_i and the occupancy does not change. At full occupancy no entry is lost.
- R9: A pop at occupancy 0 raises underflow_o for that cycle and leaves the occupancy at 0. The storage is a ring of 6 slots, and ret_addr_o always reads the slot just before the write position, including when the stack is empty. A push in the same cycle as an underflowing pop leaves the occupancy at 1.
- R10: call_i together with an acknowledged interrupt in the same cycle pushes pc_i only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call strobe (push) |
| irq_req_i | input | 1 | Pending unmasked interrupt request |
| irq_en_i | input | 1 | Global interrupt enable |
| ret_i | input | 1 | Plain return strobe (pop) |
| reti_i | input | 1 | Interrupt return strobe (pop) |
| pc_i | input | PC_W | Program-counter value to store on a push |
| ret_addr_o | output | PC_W | Newest stored address (restore value) |
| irq_ack_o | output | 1 | Interrupt acknowledge |
| full_o | output | 1 | All levels occupied |
| empty_o | output | 1 | No levels occupied |
| underflow_o | output | 1 | Pop at zero occupancy, this cycle |

## Verification
The hardest case to reach is a pending interrupt against a full stack that is popped in the same cycle. The acknowledgment must stay low in that cycle and rise only in the following one. Overwrite-at-full and push-with-pop at full are equally narrow. Directed sequences fill the stack with calls, overflow it, hold a request across the pop, and drain past empty. A long biased random run then mixes every strobe combination while a ring-buffer model in the bench predicts each output.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } stack_op_t;
endpackage

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_req_i,
  input  logic irq_en_i,
  input  logic full_i,
  output logic irq_ack_o
);
  // occupancy before this cycle's pop decides; a return must land first
  assign irq_ack_o = irq_req_i & irq_en_i & ~full_i;

  a_r7_no_ack_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !irq_ack_o);
  a_r6_ack_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (irq_req_i && irq_en_i));
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  stack_op_t                     op_i,
  output logic [$clog2(DEPTH)-1:0]      wr_addr_o,
  output logic                          wr_en_o,
  output logic [$clog2(DEPTH)-1:0]      rd_addr_o,
  output logic                          full_o,
  output logic                          empty_o,
  output logic                          underflow_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr_q, wptr_d, wptr_popped;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_popped;
  logic             pop_eff;

  function automatic logic [PTR_W-1:0] ring_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop_eff     = op_i.pop & (cnt_q != '0);
  assign underflow_o = op_i.pop & (cnt_q == '0);
  assign wptr_popped = pop_eff ? ring_dec(wptr_q) : wptr_q;
  assign cnt_popped  = pop_eff ? cnt_q - 1'b1 : cnt_q;

  always_comb begin
    wptr_d = wptr_popped;
    cnt_d  = cnt_popped;
    if (op_i.push) begin
      wptr_d = ring_inc(wptr_popped);
      if (cnt_popped != MAXC) cnt_d = cnt_popped + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wr_addr_o = wptr_popped;
  assign wr_en_o   = op_i.push;
  assign rd_addr_o = ring_dec(wptr_q);
  assign full_o    = (cnt_q == MAXC);
  assign empty_o   = (cnt_q == '0);

  a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAXC);
  a_r5_overwrite_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && op_i.push && !op_i.pop) |=> full_o);
  a_r3_pop_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.pop && !op_i.push && !empty_o) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  a_r9_underflow_stays_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !op_i.push) |=> empty_o);
  a_r8_swap_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.pop && op_i.push && !empty_o) |=> $stable(cnt_q));
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
  parameter int DEPTH = 6,
  parameter int PC_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
  input  logic [PC_W-1:0]          wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [PC_W-1:0]          rd_data_o
);
  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                   slot_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ($clog2(DEPTH))'(g)) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_addr_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int PC_W  = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic            irq_req_i,
  input  logic            irq_en_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_addr_o,
  output logic            irq_ack_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            underflow_o
);
  localparam int PTR_W = $clog2(DEPTH);

  stack_op_t        op;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic             wr_en;

  ras_irq_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .full_i    (full_o),
    .irq_ack_o (irq_ack_o)
  );

  // call and acknowledge together still store one address
  assign op.push = call_i | irq_ack_o;
  assign op.pop  = ret_i | reti_i;

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .wr_addr_o   (wr_addr),
    .wr_en_o     (wr_en),
    .rd_addr_o   (rd_addr),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .underflow_o (underflow_o)
  );

  ras_storage #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (pc_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (ret_addr_o)
  );

  a_r2_push_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op.push |=> (ret_addr_o == $past(pc_i)));
  a_r4_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  localparam int DEPTH = 6;
  localparam int PC_W  = 12;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            call_i = 0, irq_req_i = 0, irq_en_i = 0, ret_i = 0, reti_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  logic [PC_W-1:0] ret_addr_o;
  logic            irq_ack_o, full_o, empty_o, underflow_o;

  int n_vec = 0, n_bad = 0;
  logic [PC_W-1:0] m_mem [DEPTH];
  int m_w = 0, m_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) i_ret_addr_stack (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .irq_req_i(irq_req_i),
    .irq_en_i(irq_en_i), .ret_i(ret_i), .reti_i(reti_i), .pc_i(pc_i),
    .ret_addr_o(ret_addr_o), .irq_ack_o(irq_ack_o), .full_o(full_o),
    .empty_o(empty_o), .underflow_o(underflow_o));

  function automatic int rdec(int p);
    return (p == 0) ? DEPTH - 1 : p - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, check outputs before the edge, advance the model at the edge
  task automatic cyc(bit c, bit rq, bit en, bit r, bit ri, int pc, string tag);
    bit ack, push, pop;
    @(negedge clk);
    call_i = c; irq_req_i = rq; irq_en_i = en; ret_i = r; reti_i = ri;
    pc_i = PC_W'(pc);
    #2;
    ack = rq && en && (m_cnt < DEPTH);
    chk(tag, int'(ret_addr_o), int'(m_mem[rdec(m_w)]));
    chk("R4", int'(full_o), int'(m_cnt == DEPTH));
    chk("R4", int'(empty_o), int'(m_cnt == 0));
    chk((m_cnt == DEPTH && rq) ? "R7" : "R6", int'(irq_ack_o), int'(ack));
    chk("R9", int'(underflow_o), int'((r || ri) && m_cnt == 0));
    push = c || ack;
    pop  = r || ri;
    @(posedge clk);
    if (pop && m_cnt > 0) begin m_w = rdec(m_w); m_cnt--; end
    if (push) begin
      m_mem[m_w] = PC_W'(pc);
      m_w = (m_w == DEPTH - 1) ? 0 : m_w + 1;
      if (m_cnt < DEPTH) m_cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    #17;
    // R1 reset state
    chk("R1", int'(empty_o), 1);
    chk("R1", int'(full_o), 0);
    chk("R1", int'(ret_addr_o), 0);
    rst_ni = 1'b1;
    // R9 pop on empty, then pop with push on empty
    cyc(0, 0, 0, 1, 0, 'h111, "R9");
    cyc(1, 0, 0, 0, 1, 'h0AB, "R9");
    chk("R9", int'(m_cnt), 1);
    cyc(0, 0, 0, 1, 0, 'h000, "R3");
    // R2 fill with calls to full
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 0, 0, 'h100 + i, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    chk("R4", int'(full_o), 1);
    // R5 overflow twice, then drain newest first and one past empty
    cyc(1, 0, 0, 0, 0, 'h200, "R5");
    cyc(1, 0, 0, 0, 0, 'h201, "R5");
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, i[0], !i[0], 0, "R5");
    // R7 request held while full; pop and request together; then acked
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 0, 0, 'h300 + i, "R2");
    cyc(0, 1, 1, 0, 0, 'h3AA, "R7");
    cyc(0, 1, 1, 1, 0, 'h3BB, "R7");
    cyc(0, 1, 1, 0, 0, 'h3CC, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    chk("R6", int'(ret_addr_o), 'h3CC);
    // R8 push with pop at full: top replaced, nothing lost
    cyc(1, 0, 0, 0, 1, 'h3DD, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    chk("R8", int'(ret_addr_o), 'h3DD);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0, 0, "R8");
    // R10 call with acknowledged irq pushes once
    cyc(1, 1, 1, 0, 0, 'h444, "R10");
    chk("R10", int'(m_cnt), 1);
    cyc(0, 0, 0, 1, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, "R10");
    chk("R10", int'(empty_o), 1);
    // R6 disabled request ignored
    cyc(0, 1, 0, 0, 0, 'h555, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    chk("R6", int'(empty_o), 1);
    // biased random sweep over all strobe combinations
    for (int i = 0; i < 20000; i++) begin
      int phase = (i / 300) % 3;
      int pu = (phase == 0) ? 60 : (phase == 1) ? 25 : 45;
      int po = (phase == 0) ? 25 : (phase == 1) ? 60 : 45;
      cyc(($urandom % 100) < pu, ($urandom % 100) < 30, ($urandom % 4) != 0,
          ($urandom % 100) < po / 2, ($urandom % 100) < po / 2,
          int'($urandom % 4096), "R3");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule